// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns one memory operand of a 16-bit segmented processor running in real mode into a physical address. Each request carries three parts, and any of them may be left out: an optional base register (the BX class or the BP class), an optional index register (the SI class or the DI class), and a displacement. The block adds these parts into a 16-bit offset. It then picks a segment register, shifts that segment's value left by four bits and adds the offset. The result is an address in a 1-megabyte space.

The segment normally follows from the operand itself. Operands that use the BP-class base go to the stack segment, and all other operands go to the data segment. A prefix strobe can latch an override segment. That override holds for every request until the next instruction-boundary strobe, and is then dropped. A wide mode forms the offset from 32-bit register values. Real mode cannot reach more than 64K, so the block raises a protection fault in place of an address when a wide offset does not fit in 16 bits. Results appear one clock after the request, together with a one-cycle valid pulse.

Top module: `seg_addr_gen`

## Requirements
- R1: In narrow mode (req_wide=0), ea_ofs is the sum modulo 2^16 of the low 16 bits of base_val, the low 16 bits of idx_val and the displacement. base_val is counted only when base_sel is 2'b01 (BX class) or 2'b10 (BP class). idx_val is counted only when idx_sel is 2'b01 (SI class) or 2'b10 (DI class). The code 2'b11 means absent.
- R2: With disp_short=1, the displacement is disp[7:0] sign-extended, and disp[15:8] is ignored. With disp_short=0, all 16 bits of disp are used as a signed value.
- R3: With no override pending, seg_id is 3 (data segment), or 2 (stack segment) when base_sel is 2'b10. The segment codes are: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS.
- R4: A legal ovr_stb latches ovr_code. Every following request uses that segment until a cycle with insn_end=1 clears it. If ovr_stb and insn_end arrive in the same cycle, the new override is latched.
- R5: ovr_illegal is raised one cycle after an ovr_stb whose code is 6 or 7, or whose code is 4 or 5 while EXT_SEGS=0. Such an override is not latched.
- R6: pa equals segment value times 16 plus ea_ofs, modulo 2^20.
- R7: In wide mode the offset is the 32-bit sum of base, index and sign-extended displacement. If that sum is outside 0 to 0xFFFF, gp_fault pulses and pa_vld stays low. In that case ea_ofs, seg_id and pa keep their previous values.
- R8: Outputs update on the clock edge that samples req_vld=1. pa_vld is a one-cycle pulse that only follows a request.
- R9: Reset clears the pending override and drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Address request strobe |
| req_wide | input | 1 | Use 32-bit register values with range check |
| base_sel | input | 2 | Base select: 0 none, 1 BX class, 2 BP class, 3 none |
| base_val | input | WIDE_W (32) | Value of the selected base register |
| idx_sel | input | 2 | Index select: 0 none, 1 SI class, 2 DI class, 3 none |
| idx_val | input | WIDE_W (32) | Value of the selected index register |
| disp | input | OFS_W (16) | Signed displacement |
| disp_short | input | 1 | Use sign-extended disp[7:0] only |
| seg_es | input | SEG_W (16) | Segment value, code 0 |
| seg_cs | input | SEG_W (16) | Segment value, code 1 |
| seg_ss | input | SEG_W (16) | Segment value, code 2 |
| seg_ds | input | SEG_W (16) | Segment value, code 3 |
| seg_fs | input | SEG_W (16) | Segment value, code 4 (extension) |
| seg_gs | input | SEG_W (16) | Segment value, code 5 (extension) |
| ovr_stb | input | 1 | Segment-override prefix strobe |
| ovr_code | input | 3 | Override segment code |
| insn_end | input | 1 | Instruction-boundary strobe |
| ea_ofs | output | OFS_W (16) | Effective offset |
| seg_id | output | 3 | Segment code used |
| pa | output | SEG_W+SEG_SHIFT (20) | Physical address |
| pa_vld | output | 1 | Address valid pulse |
| gp_fault | output | 1 | Wide offset out of range pulse |
| ovr_illegal | output | 1 | Rejected override pulse |

## Verification
The bench builds two instances. Both use OFS_W=16, SEG_W=16, SEG_SHIFT=4 and WIDE_W=32. One has EXT_SEGS=1 and the other EXT_SEGS=0. The wide 32-bit inputs make the protection fault reachable, and so is the case where a negative displacement brings a wide sum back into range. A segment value near the top of memory drives the 20-bit sum past its wrap point. The instance without the extension exercises the rejection of the FS and GS codes, while the same strobes are accepted by the other instance.

// File: rtl/sag_pkg.sv
package sag_pkg;

  typedef enum logic [2:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_id_e;

  localparam logic [1:0] BASE_BX = 2'b01;
  localparam logic [1:0] BASE_BP = 2'b10;
  localparam logic [1:0] IDX_SI  = 2'b01;
  localparam logic [1:0] IDX_DI  = 2'b10;
  localparam int         SHORT_DISP_W = 8;

  // True when a segment code names a register that exists in this build.
  function automatic logic seg_code_ok(input logic [2:0] code, input bit ext);
    return (code <= 3'd3) || (ext && ((code == 3'd4) || (code == 3'd5)));
  endfunction

endpackage

// File: rtl/sag_offset.sv
module sag_offset
  import sag_pkg::*;
#(
  parameter int OFS_W  = 16,
  parameter int WIDE_W = 32
) (
  input  logic [1:0]        base_sel,
  input  logic [WIDE_W-1:0] base_val,
  input  logic [1:0]        idx_sel,
  input  logic [WIDE_W-1:0] idx_val,
  input  logic [OFS_W-1:0]  disp,
  input  logic              disp_short,
  input  logic              wide,
  output logic [OFS_W-1:0]  ofs,
  output logic              over_range
);

  localparam int HI_W = WIDE_W - OFS_W;

  logic [WIDE_W-1:0] base_term;
  logic [WIDE_W-1:0] idx_term;
  logic [WIDE_W-1:0] disp_term;
  logic [WIDE_W-1:0] sum;

  always_comb begin
    base_term = ((base_sel == BASE_BX) || (base_sel == BASE_BP)) ? base_val : '0;
    idx_term  = ((idx_sel == IDX_SI) || (idx_sel == IDX_DI)) ? idx_val : '0;
    if (disp_short) begin
      disp_term = {{(WIDE_W-SHORT_DISP_W){disp[SHORT_DISP_W-1]}}, disp[SHORT_DISP_W-1:0]};
    end else begin
      disp_term = {{(WIDE_W-OFS_W){disp[OFS_W-1]}}, disp};
    end
    // Low bits of the wide sum are the modulo-2^OFS_W narrow sum.
    sum        = base_term + idx_term + disp_term;
    ofs        = sum[OFS_W-1:0];
    over_range = wide && (sum[WIDE_W-1:OFS_W] != {HI_W{1'b0}});
  end

endmodule

// File: rtl/sag_override.sv
module sag_override
  import sag_pkg::*;
#(
  parameter bit EXT_SEGS = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovr_stb,
  input  logic [2:0] ovr_code,
  input  logic       insn_end,
  input  logic       uses_bp,
  output logic [2:0] seg_pick,
  output logic       ovr_illegal
);

  logic       act_q, act_d;
  logic [2:0] code_q, code_d;
  logic       ill_q, ill_d;
  logic       legal;

  always_comb begin
    legal  = seg_code_ok(ovr_code, EXT_SEGS);
    act_d  = act_q;
    code_d = code_q;
    ill_d  = ovr_stb && !legal;
    if (insn_end) begin
      act_d = 1'b0;
    end
    if (ovr_stb && legal) begin
      act_d  = 1'b1;
      code_d = ovr_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      code_q <= 3'd0;
      ill_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      code_q <= code_d;
      ill_q  <= ill_d;
    end
  end

  always_comb begin
    if (act_q) begin
      seg_pick = code_q;
    end else if (uses_bp) begin
      seg_pick = SEG_SS;
    end else begin
      seg_pick = SEG_DS;
    end
  end

  assign ovr_illegal = ill_q;

  assert_ovr_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_end && !ovr_stb) |=> !act_q);
  assert_ovr_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_stb && seg_code_ok(ovr_code, EXT_SEGS)) |=> (act_q && (code_q == $past(ovr_code))));
  assert_latch_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> seg_code_ok(code_q, EXT_SEGS));
  assert_illegal_follows_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_illegal |-> $past(ovr_stb));

endmodule

// File: rtl/sag_phys.sv
module sag_phys #(
  parameter int SEG_W     = 16,
  parameter int OFS_W     = 16,
  parameter int SEG_SHIFT = 4
) (
  input  logic [SEG_W-1:0]           seg_val,
  input  logic [OFS_W-1:0]           ofs,
  output logic [SEG_W+SEG_SHIFT-1:0] pa
);

  localparam int PA_W = SEG_W + SEG_SHIFT;

  logic [PA_W-1:0] seg_base;
  logic [PA_W-1:0] ofs_ext;

  always_comb begin
    seg_base = {seg_val, {SEG_SHIFT{1'b0}}};
    ofs_ext  = PA_W'(ofs);
    pa       = seg_base + ofs_ext;
  end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import sag_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int WIDE_W    = 32,
  parameter bit EXT_SEGS  = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_vld,
  input  logic                       req_wide,
  input  logic [1:0]                 base_sel,
  input  logic [WIDE_W-1:0]          base_val,
  input  logic [1:0]                 idx_sel,
  input  logic [WIDE_W-1:0]          idx_val,
  input  logic [OFS_W-1:0]           disp,
  input  logic                       disp_short,
  input  logic [SEG_W-1:0]           seg_es,
  input  logic [SEG_W-1:0]           seg_cs,
  input  logic [SEG_W-1:0]           seg_ss,
  input  logic [SEG_W-1:0]           seg_ds,
  input  logic [SEG_W-1:0]           seg_fs,
  input  logic [SEG_W-1:0]           seg_gs,
  input  logic                       ovr_stb,
  input  logic [2:0]                 ovr_code,
  input  logic                       insn_end,
  output logic [OFS_W-1:0]           ea_ofs,
  output logic [2:0]                 seg_id,
  output logic [SEG_W+SEG_SHIFT-1:0] pa,
  output logic                       pa_vld,
  output logic                       gp_fault,
  output logic                       ovr_illegal
);

  localparam int PA_W     = SEG_W + SEG_SHIFT;
  localparam int N_CODES  = 8;
  localparam int SYNC_LEN = 2;

  // Reset: asserted at once, released after SYNC_LEN clock edges.
  logic [SYNC_LEN-1:0] rst_sync_q;
  logic                rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_LEN-2:0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync_q[SYNC_LEN-1];

  // Segment table indexed by code.
  logic [SEG_W-1:0] seg_tab [N_CODES];
  assign seg_tab[SEG_ES] = seg_es;
  assign seg_tab[SEG_CS] = seg_cs;
  assign seg_tab[SEG_SS] = seg_ss;
  assign seg_tab[SEG_DS] = seg_ds;
  assign seg_tab[6]      = '0;
  assign seg_tab[7]      = '0;
  generate
    if (EXT_SEGS) begin : g_ext
      assign seg_tab[SEG_FS] = seg_fs;
      assign seg_tab[SEG_GS] = seg_gs;
    end else begin : g_noext
      logic [2*SEG_W-1:0] unused_ext;
      assign unused_ext      = {seg_fs, seg_gs};
      assign seg_tab[SEG_FS] = '0;
      assign seg_tab[SEG_GS] = '0;
    end
  endgenerate

  logic [OFS_W-1:0] ofs_w;
  logic             over_range;
  logic [2:0]       seg_pick;
  logic [PA_W-1:0]  pa_w;

  sag_offset #(.OFS_W(OFS_W), .WIDE_W(WIDE_W)) u_offset (
    .base_sel   (base_sel),
    .base_val   (base_val),
    .idx_sel    (idx_sel),
    .idx_val    (idx_val),
    .disp       (disp),
    .disp_short (disp_short),
    .wide       (req_wide),
    .ofs        (ofs_w),
    .over_range (over_range)
  );

  sag_override #(.EXT_SEGS(EXT_SEGS)) u_override (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .ovr_stb     (ovr_stb),
    .ovr_code    (ovr_code),
    .insn_end    (insn_end),
    .uses_bp     (base_sel == BASE_BP),
    .seg_pick    (seg_pick),
    .ovr_illegal (ovr_illegal)
  );

  sag_phys #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_phys (
    .seg_val (seg_tab[seg_pick]),
    .ofs     (ofs_w),
    .pa      (pa_w)
  );

  // Output registers.
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic [2:0]       seg_q, seg_d;
  logic [PA_W-1:0]  pa_q, pa_d;
  logic             vld_q, vld_d;
  logic             flt_q, flt_d;
  logic             load_en;

  always_comb begin
    load_en = req_vld && !over_range;
    vld_d   = load_en;
    flt_d   = req_vld && over_range;
    ofs_d   = ofs_q;
    seg_d   = seg_q;
    pa_d    = pa_q;
    if (load_en) begin
      ofs_d = ofs_w;
      seg_d = seg_pick;
      pa_d  = pa_w;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ofs_q <= '0;
      seg_q <= 3'd0;
      pa_q  <= '0;
      vld_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      ofs_q <= ofs_d;
      seg_q <= seg_d;
      pa_q  <= pa_d;
      vld_q <= vld_d;
      flt_q <= flt_d;
    end
  end

  assign ea_ofs   = ofs_q;
  assign seg_id   = seg_q;
  assign pa       = pa_q;
  assign pa_vld   = vld_q;
  assign gp_fault = flt_q;

  assert_vld_excl_fault_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(pa_vld && gp_fault));
  assert_fault_only_wide_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    gp_fault |-> $past(req_vld && req_wide));
  assert_hold_on_fault_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    gp_fault |-> ($stable(pa) && $stable(ea_ofs)));
  assert_vld_after_req_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    pa_vld |-> $past(req_vld));
  assert_seg_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    pa_vld |-> seg_code_ok(seg_id, EXT_SEGS));

endmodule

// File: tb/test_seg_addr_gen.sv
module test_seg_addr_gen;

  localparam logic [15:0] V_ES = 16'h3000;
  localparam logic [15:0] V_CS = 16'h1000;
  localparam logic [15:0] V_SS = 16'h4000;
  localparam logic [15:0] V_DS = 16'h2000;
  localparam logic [15:0] V_FS = 16'h5000;
  localparam logic [15:0] V_GS = 16'hF800;

  typedef struct packed {
    logic [1:0]  bs;
    logic [31:0] bv;
    logic [1:0]  is;
    logic [31:0] iv;
    logic [15:0] d;
    logic        sh;
    logic        wd;
    logic        ov;
    logic [2:0]  oc;
    logic [15:0] eofs;
    logic [2:0]  eseg;
    logic        eflt;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 32'h0000_1234, 2'd0, 32'h0,         16'h0000, 1'b0, 1'b0, 1'b0, 3'd0, 16'h1234, 3'd3, 1'b0},
    '{2'd2, 32'h0000_0100, 2'd1, 32'h0000_0020, 16'h0005, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0125, 3'd2, 1'b0},
    '{2'd0, 32'h0000_5555, 2'd2, 32'h0000_8000, 16'h9000, 1'b0, 1'b0, 1'b0, 3'd0, 16'h1000, 3'd3, 1'b0},
    '{2'd1, 32'h0000_FFFF, 2'd1, 32'h0000_0002, 16'h0000, 1'b0, 1'b0, 1'b0, 3'd0, 16'h0001, 3'd3, 1'b0},
    '{2'd1, 32'h0000_0100, 2'd0, 32'h0,         16'h00F0, 1'b1, 1'b0, 1'b0, 3'd0, 16'h00F0, 3'd3, 1'b0},
    '{2'd0, 32'h0,         2'd0, 32'h0000_7777, 16'hAB7F, 1'b1, 1'b0, 1'b0, 3'd0, 16'h007F, 3'd3, 1'b0},
    '{2'd2, 32'h0000_0010, 2'd0, 32'h0,         16'h0000, 1'b0, 1'b0, 1'b1, 3'd3, 16'h0010, 3'd3, 1'b0},
    '{2'd1, 32'h0000_0004, 2'd0, 32'h0,         16'h0000, 1'b0, 1'b0, 1'b1, 3'd0, 16'h0004, 3'd0, 1'b0},
    '{2'd0, 32'h0,         2'd0, 32'h0,         16'hFFFF, 1'b0, 1'b0, 1'b1, 3'd5, 16'hFFFF, 3'd5, 1'b0},
    '{2'd1, 32'h0000_FFF0, 2'd1, 32'h0000_000F, 16'h0000, 1'b0, 1'b1, 1'b0, 3'd0, 16'hFFFF, 3'd3, 1'b0},
    '{2'd1, 32'h0000_FFF0, 2'd2, 32'h0000_0010, 16'h0000, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0000, 3'd3, 1'b1},
    '{2'd1, 32'h0000_0010, 2'd0, 32'h0,         16'hFFF0, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0000, 3'd3, 1'b0},
    '{2'd2, 32'h0000_0010, 2'd0, 32'h0,         16'hFFE0, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0000, 3'd2, 1'b1},
    '{2'd1, 32'h0001_2345, 2'd0, 32'h0,         16'h0000, 1'b0, 1'b0, 1'b0, 3'd0, 16'h2345, 3'd3, 1'b0},
    '{2'd2, 32'h0000_0040, 2'd0, 32'h0,         16'h0000, 1'b0, 1'b0, 1'b1, 3'd4, 16'h0040, 3'd4, 1'b0},
    '{2'd3, 32'h0000_1111, 2'd3, 32'h0000_2222, 16'h4321, 1'b0, 1'b0, 1'b0, 3'd0, 16'h4321, 3'd3, 1'b0},
    '{2'd2, 32'h0000_0100, 2'd0, 32'h0,         16'h0080, 1'b1, 1'b1, 1'b0, 3'd0, 16'h0080, 3'd2, 1'b0},
    '{2'd1, 32'h0001_0000, 2'd0, 32'h0,         16'h0000, 1'b0, 1'b1, 1'b0, 3'd0, 16'h0000, 3'd3, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_vld = 1'b0, req_wide = 1'b0;
  logic [1:0]  base_sel = 2'd0, idx_sel = 2'd0;
  logic [31:0] base_val = '0, idx_val = '0;
  logic [15:0] disp = '0;
  logic        disp_short = 1'b0;
  logic        ovr_stb = 1'b0, insn_end = 1'b0;
  logic [2:0]  ovr_code = 3'd0;

  logic [15:0] ea_ofs, ea_ofs_n;
  logic [2:0]  seg_id, seg_id_n;
  logic [19:0] pa, pa_n;
  logic        pa_vld, pa_vld_n, gp_fault, gp_fault_n, ovr_illegal, ovr_illegal_n;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  seg_addr_gen #(.EXT_SEGS(1'b1)) i_seg_addr_gen (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wide(req_wide),
    .base_sel(base_sel), .base_val(base_val), .idx_sel(idx_sel), .idx_val(idx_val),
    .disp(disp), .disp_short(disp_short),
    .seg_es(V_ES), .seg_cs(V_CS), .seg_ss(V_SS), .seg_ds(V_DS), .seg_fs(V_FS), .seg_gs(V_GS),
    .ovr_stb(ovr_stb), .ovr_code(ovr_code), .insn_end(insn_end),
    .ea_ofs(ea_ofs), .seg_id(seg_id), .pa(pa), .pa_vld(pa_vld),
    .gp_fault(gp_fault), .ovr_illegal(ovr_illegal)
  );

  seg_addr_gen #(.EXT_SEGS(1'b0)) i_seg_addr_gen_noext (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wide(req_wide),
    .base_sel(base_sel), .base_val(base_val), .idx_sel(idx_sel), .idx_val(idx_val),
    .disp(disp), .disp_short(disp_short),
    .seg_es(V_ES), .seg_cs(V_CS), .seg_ss(V_SS), .seg_ds(V_DS), .seg_fs(V_FS), .seg_gs(V_GS),
    .ovr_stb(ovr_stb), .ovr_code(ovr_code), .insn_end(insn_end),
    .ea_ofs(ea_ofs_n), .seg_id(seg_id_n), .pa(pa_n), .pa_vld(pa_vld_n),
    .gp_fault(gp_fault_n), .ovr_illegal(ovr_illegal_n)
  );

  function automatic logic [19:0] exp_pa(input logic [2:0] s, input logic [15:0] o);
    logic [15:0] v;
    case (s)
      3'd0: v = V_ES;
      3'd1: v = V_CS;
      3'd2: v = V_SS;
      3'd3: v = V_DS;
      3'd4: v = V_FS;
      default: v = V_GS;
    endcase
    return 20'((v * 32'd16 + o) % 32'h10_0000);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_ovr(input logic [2:0] code);
    @(negedge clk);
    ovr_stb  = 1'b1;
    ovr_code = code;
    @(negedge clk);
    ovr_stb  = 1'b0;
  endtask

  task automatic pulse_end();
    @(negedge clk);
    insn_end = 1'b1;
    @(negedge clk);
    insn_end = 1'b0;
  endtask

  task automatic do_req(input logic [1:0] bs, input logic [31:0] bv, input logic [1:0] is,
                        input logic [31:0] iv, input logic [15:0] d, input logic sh, input logic wd);
    @(negedge clk);
    base_sel = bs; base_val = bv; idx_sel = is; idx_val = iv;
    disp = d; disp_short = sh; req_wide = wd; req_vld = 1'b1;
    @(negedge clk);
    req_vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [19:0] pa_before;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 ea_ofs", 32'(ea_ofs), 0);
    check("R9 pa", 32'(pa), 0);
    check("R9 flags", {29'd0, pa_vld, gp_fault, ovr_illegal}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Vector table: R1 R2 R3 R4 R6 R7
    for (int k = 0; k < NV; k++) begin
      if (VEC[k].ov) pulse_ovr(VEC[k].oc);
      pa_before = pa;
      do_req(VEC[k].bs, VEC[k].bv, VEC[k].is, VEC[k].iv, VEC[k].d, VEC[k].sh, VEC[k].wd);
      if (VEC[k].eflt) begin
        check($sformatf("R7 fault v%0d", k), {30'd0, gp_fault, pa_vld}, 32'd2);
        check($sformatf("R7 hold pa v%0d", k), 32'(pa), 32'(pa_before));
      end else begin
        check($sformatf("R8 vld v%0d", k), {30'd0, gp_fault, pa_vld}, 32'd1);
        check($sformatf("R1 R2 ofs v%0d", k), 32'(ea_ofs), 32'(VEC[k].eofs));
        check($sformatf("R3 R4 seg v%0d", k), 32'(seg_id), 32'(VEC[k].eseg));
        check($sformatf("R6 pa v%0d", k), 32'(pa), 32'(exp_pa(VEC[k].eseg, VEC[k].eofs)));
      end
      @(negedge clk);
      check($sformatf("R8 pulse ends v%0d", k), {30'd0, gp_fault, pa_vld}, 0);
      pulse_end();
    end

    // R4: override persists across requests until boundary
    pulse_ovr(3'd1);
    do_req(2'd2, 32'h10, 2'd0, 0, 16'h0, 1'b0, 1'b0);
    check("R4 first use CS", 32'(seg_id), 1);
    do_req(2'd1, 32'h20, 2'd0, 0, 16'h0, 1'b0, 1'b0);
    check("R4 second use CS", 32'(seg_id), 1);
    pulse_end();
    do_req(2'd2, 32'h10, 2'd0, 0, 16'h0, 1'b0, 1'b0);
    check("R4 cleared to SS", 32'(seg_id), 2);

    // R4: strobe and boundary in same cycle -> new override latched
    @(negedge clk);
    ovr_stb = 1'b1; ovr_code = 3'd0; insn_end = 1'b1;
    @(negedge clk);
    ovr_stb = 1'b0; insn_end = 1'b0;
    do_req(2'd1, 32'h30, 2'd0, 0, 16'h0, 1'b0, 1'b0);
    check("R4 same-cycle ES", 32'(seg_id), 0);
    pulse_end();

    // R5: code 6 rejected on both builds
    pulse_ovr(3'd6);
    check("R5 illegal code6", 32'(ovr_illegal), 1);
    check("R5 illegal code6 noext", 32'(ovr_illegal_n), 1);
    do_req(2'd1, 32'h40, 2'd0, 0, 16'h0, 1'b0, 1'b0);
    check("R5 not latched", 32'(seg_id), 3);
    pulse_end();

    // R5: FS rejected only without the extension
    pulse_ovr(3'd4);
    check("R5 FS ok with ext", 32'(ovr_illegal), 0);
    check("R5 FS bad without ext", 32'(ovr_illegal_n), 1);
    do_req(2'd1, 32'h50, 2'd0, 0, 16'h0, 1'b0, 1'b0);
    check("R5 ext uses FS", 32'(seg_id), 4);
    check("R5 noext stays DS", 32'(seg_id_n), 3);
    check("R6 noext pa", 32'(pa_n), 32'(exp_pa(3'd3, 16'h50)));
    pulse_end();

    // R9: reset drops a pending override
    pulse_ovr(3'd0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 outputs cleared", 32'(pa), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_req(2'd1, 32'h60, 2'd0, 0, 16'h0, 1'b0, 1'b0);
    check("R9 override dropped", 32'(seg_id), 3);

    // R8: no pulse without a request
    repeat (3) @(negedge clk);
    check("R8 idle", {30'd0, gp_fault, pa_vld}, 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule